// File: doc/BRIEF.md
# Pipeline Exception Commit Controller

This block handles faults and external interrupts for a five-stage in-order pipeline made of fetch, decode, execute, memory and writeback stages. It does not act on a fault in the stage that sees it. Each fault is recorded as a flag and a cause code. The flag moves down the pipeline beside the valid bit and PC of its instruction. The controller makes its decision only when the instruction reaches the commit point in the memory stage.

When the instruction at the commit point has a recorded fault, or the external interrupt line is high, the controller takes the exception in that cycle. It kills the fetch, decode and execute stages, suppresses the writeback of the faulting instruction, and steers fetch to a fixed handler address. At the next clock edge it loads the cause and exception-PC registers. Every instruction older than the faulting one has already retired, so the event falls exactly between two instructions.

The datapath lives elsewhere. It reports per-stage fault strobes and the fetch PC. In return it receives the kill lines, the handler redirect, the cause and exception PC, and a retire strobe for each instruction that leaves the commit point normally. The reset input is assumed to be released synchronously upstream.

Top module: `exc_commit_ctrl`

## Requirements
- R1: While reset is low and afterwards until an instruction reaches the commit point, take, retire, all kill lines and the handler select are low, and cause and exception PC read 0.
- R2: A fault raised in any stage has no visible effect until its instruction reaches the memory stage. An instruction fetched in cycle n is resolved, by a take or a retire, in cycle n+3.
- R3: When one instruction collects faults in several stages, the cause from the earliest stage is kept. The codes are 1 for a fetch address fault, 2 for an illegal opcode, 3 for an overflow and 4 for a data address fault.
- R4: An external interrupt seen while a valid instruction sits at the commit point is taken with cause 0, whatever faults that instruction carries.
- R5: In the take cycle, all four kill lines and the handler select are high. The handler address output always equals the HANDLER_PC parameter.
- R6: The cycle after a take, the cause output shows the committed cause and the exception PC shows the PC of the instruction at the commit point. Both hold their values through cycles without a take.
- R7: The three younger instructions that occupy fetch, decode and execute in the take cycle never retire and never raise an exception, whatever faults are reported for them.
- R8: A fault-free valid instruction at the commit point with no interrupt retires. Retire is high for one cycle and the commit PC output shows the instruction's PC.
- R9: Fault strobes for a bubble, meaning a stage with no valid instruction, are ignored. An interrupt is not taken while the commit stage holds a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_valid_i | input | 1 | Fetch stage holds a valid instruction |
| if_pc_i | input | PC_W | PC of the instruction in fetch |
| if_pc_fault_i | input | 1 | Fetch address fault for the fetch-stage instruction |
| id_illegal_i | input | 1 | Illegal opcode for the decode-stage instruction |
| ex_overflow_i | input | 1 | Arithmetic overflow for the execute-stage instruction |
| mem_addr_fault_i | input | 1 | Data address fault for the memory-stage instruction |
| ext_irq_i | input | 1 | External interrupt request |
| take_o | output | 1 | Exception taken this cycle |
| kill_if_o | output | 1 | Squash the fetch stage |
| kill_id_o | output | 1 | Squash the decode stage |
| kill_ex_o | output | 1 | Squash the execute stage |
| kill_wb_o | output | 1 | Suppress writeback of the committing instruction |
| pc_sel_handler_o | output | 1 | Fetch the next instruction from the handler address |
| handler_pc_o | output | PC_W | Handler address |
| retire_o | output | 1 | Commit-stage instruction retires normally |
| commit_pc_o | output | PC_W | PC of the instruction at the commit point |
| cause_o | output | 3 | Cause register |
| epc_o | output | PC_W | Exception PC register |

## Verification
The hardest case to reach from the ports is a single instruction that collects faults in several stages while younger instructions right behind it carry their own faults. Those younger faults must vanish when the older one commits. The bench handles this by describing each test as a program of instruction slots, where every slot has its own per-stage fault flags and an interrupt flag. The driver replays each flag in the cycle its slot sits in that stage, so squashed and bubble slots still put live fault strobes on the inputs. A scoreboard entry names the exact cycle, the kind of event and the PC expected for each surviving slot.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
  localparam int CAUSE_W = 3;

  // Cause codes; the bench and software decode these values.
  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_IRQ     = 3'd0,
    CAUSE_IFETCH  = 3'd1,
    CAUSE_ILLEGAL = 3'd2,
    CAUSE_OVF     = 3'd3,
    CAUSE_DADDR   = 3'd4
  } cause_e;

  // Per-instruction status carried alongside each stage.
  typedef struct packed {
    logic   valid;
    logic   exc;
    cause_e cause;
  } tag_t;
endpackage

// File: rtl/exc_stage.sv
`timescale 1ns/1ps
// One pipeline slot of exception status: registers the upstream tag and PC,
// then merges this stage's own fault only if no older fault is already held.
module exc_stage
  import exc_pkg::*;
#(
  parameter int     PC_W        = 32,
  parameter cause_e LOCAL_CAUSE = CAUSE_ILLEGAL
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush_i,
  input  tag_t            tag_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            fault_i,
  output tag_t            tag_o,
  output logic [PC_W-1:0] pc_o
);

  tag_t            tag_d, tag_q;
  logic [PC_W-1:0] pc_q;
  logic            pc_en;

  always_comb begin
    tag_d = tag_i;
    if (flush_i) tag_d = '0;
    pc_en = tag_i.valid && !flush_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      pc_q  <= '0;
    end else begin
      tag_q <= tag_d;
      if (pc_en) pc_q <= pc_i;
    end
  end

  always_comb begin
    tag_o = tag_q;
    if (tag_q.valid && !tag_q.exc && fault_i) begin
      tag_o.exc   = 1'b1;
      tag_o.cause = LOCAL_CAUSE;
    end
  end

  assign pc_o = pc_q;

  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !tag_q.valid);

  assert_older_fault_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_i.valid && tag_i.exc && !flush_i) |=> (tag_o.exc && tag_o.cause == $past(tag_i.cause)));

  assert_bubble_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_q.valid |-> !tag_o.exc);

endmodule

// File: rtl/exc_commit.sv
`timescale 1ns/1ps
// Commit point: decides take or retire for the memory-stage instruction and
// owns the cause and exception-PC registers.
module exc_commit
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  tag_t               mem_tag_i,
  input  logic [PC_W-1:0]    mem_pc_i,
  input  logic               irq_i,
  output logic               take_o,
  output logic               retire_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [PC_W-1:0]    epc_o
);

  logic            take;
  cause_e          cause_d, cause_q;
  logic [PC_W-1:0] epc_q;

  always_comb begin
    take    = mem_tag_i.valid && (irq_i || mem_tag_i.exc);
    cause_d = irq_i ? CAUSE_IRQ : mem_tag_i.cause;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= CAUSE_IRQ;
      epc_q   <= '0;
    end else if (take) begin
      cause_q <= cause_d;
      epc_q   <= mem_pc_i;
    end
  end

  assign take_o   = take;
  assign retire_o = mem_tag_i.valid && !take;
  assign cause_o  = cause_q;
  assign epc_o    = epc_q;

  assert_irq_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_tag_i.valid && irq_i) |=> (cause_q == CAUSE_IRQ));

  assert_epc_loaded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (epc_q == $past(mem_pc_i)));

  assert_regs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |=> ($stable(cause_q) && $stable(epc_q)));

  assert_bubble_no_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_tag_i.valid |-> (!take_o && !retire_o));

endmodule

// File: rtl/exc_commit_ctrl.sv
`timescale 1ns/1ps
module exc_commit_ctrl
  import exc_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0180
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               if_valid_i,
  input  logic [PC_W-1:0]    if_pc_i,
  input  logic               if_pc_fault_i,
  input  logic               id_illegal_i,
  input  logic               ex_overflow_i,
  input  logic               mem_addr_fault_i,
  input  logic               ext_irq_i,
  output logic               take_o,
  output logic               kill_if_o,
  output logic               kill_id_o,
  output logic               kill_ex_o,
  output logic               kill_wb_o,
  output logic               pc_sel_handler_o,
  output logic [PC_W-1:0]    handler_pc_o,
  output logic               retire_o,
  output logic [PC_W-1:0]    commit_pc_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [PC_W-1:0]    epc_o
);

  localparam int NSTG = 3;  // decode, execute, memory slots after fetch

  tag_t            chain    [NSTG+1];
  logic [PC_W-1:0] pc_chain [NSTG+1];
  logic [NSTG:1]   stg_fault;
  logic            take;

  always_comb begin
    chain[0].valid = if_valid_i;
    chain[0].exc   = if_valid_i && if_pc_fault_i;
    chain[0].cause = CAUSE_IFETCH;
    pc_chain[0]    = if_pc_i;
    stg_fault      = {mem_addr_fault_i, ex_overflow_i, id_illegal_i};
  end

  // Stage g reports cause code g+1 (decode=2, execute=3, memory=4).
  for (genvar g = 1; g <= NSTG; g++) begin : g_stg
    exc_stage #(
      .PC_W        (PC_W),
      .LOCAL_CAUSE (cause_e'(g + 1))
    ) u_stg (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (take),
      .tag_i   (chain[g-1]),
      .pc_i    (pc_chain[g-1]),
      .fault_i (stg_fault[g]),
      .tag_o   (chain[g]),
      .pc_o    (pc_chain[g])
    );
  end

  exc_commit #(.PC_W(PC_W)) u_commit (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_tag_i (chain[NSTG]),
    .mem_pc_i  (pc_chain[NSTG]),
    .irq_i     (ext_irq_i),
    .take_o    (take),
    .retire_o  (retire_o),
    .cause_o   (cause_o),
    .epc_o     (epc_o)
  );

  assign take_o           = take;
  assign kill_if_o        = take;
  assign kill_id_o        = take;
  assign kill_ex_o        = take;
  assign kill_wb_o        = take;
  assign pc_sel_handler_o = take;
  assign handler_pc_o     = HANDLER_PC;
  assign commit_pc_o      = pc_chain[NSTG];

  assert_take_needs_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> chain[NSTG].valid);

endmodule

// File: tb/exc_commit_ctrl_bench.sv
`timescale 1ns/1ps
module exc_commit_ctrl_bench;
  localparam int          PC_W    = 32;
  localparam logic [31:0] HANDLER = 32'h0000_0180;
  localparam int          MAXP    = 32;

  typedef struct packed {
    logic        is_take;
    logic [31:0] pc;
    logic [2:0]  cause;
    logic [31:0] cyc;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            if_valid_i = 0, if_pc_fault_i = 0, id_illegal_i = 0;
  logic            ex_overflow_i = 0, mem_addr_fault_i = 0, ext_irq_i = 0;
  logic [PC_W-1:0] if_pc_i = '0;
  logic            take_o, kill_if_o, kill_id_o, kill_ex_o, kill_wb_o, pc_sel_handler_o, retire_o;
  logic [PC_W-1:0] handler_pc_o, commit_pc_o, epc_o;
  logic [2:0]      cause_o;

  exc_commit_ctrl #(.PC_W(PC_W), .HANDLER_PC(HANDLER)) u_exc_commit_ctrl (
    .clk(clk), .rst_n(rst_n), .if_valid_i(if_valid_i), .if_pc_i(if_pc_i),
    .if_pc_fault_i(if_pc_fault_i), .id_illegal_i(id_illegal_i),
    .ex_overflow_i(ex_overflow_i), .mem_addr_fault_i(mem_addr_fault_i),
    .ext_irq_i(ext_irq_i), .take_o(take_o), .kill_if_o(kill_if_o),
    .kill_id_o(kill_id_o), .kill_ex_o(kill_ex_o), .kill_wb_o(kill_wb_o),
    .pc_sel_handler_o(pc_sel_handler_o), .handler_pc_o(handler_pc_o),
    .retire_o(retire_o), .commit_pc_o(commit_pc_o), .cause_o(cause_o), .epc_o(epc_o)
  );

  int   total = 0, bad = 0;
  logic done = 0, started = 0;
  logic [31:0] cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  ev_t exp_q[$];

  logic        p_v [MAXP], p_fi [MAXP], p_fd [MAXP], p_fe [MAXP], p_fm [MAXP], p_irq [MAXP];
  logic [31:0] p_pc [MAXP];
  int          n_prog = 0;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic add(input logic v, input logic [31:0] pc, input logic fi, input logic fd,
                     input logic fe, input logic fm, input logic irq);
    p_v[n_prog] = v;   p_pc[n_prog] = pc;  p_fi[n_prog] = fi; p_fd[n_prog] = fd;
    p_fe[n_prog] = fe; p_fm[n_prog] = fm;  p_irq[n_prog] = irq;
    n_prog++;
  endtask

  // Driver: computes expected events from the requirements, then replays the
  // program with each slot's fault flags in the cycle the slot sits in that stage.
  task automatic run_prog(input string req);
    logic [31:0] base;
    int          skip;
    ev_t         e;
    @(posedge clk); #1;
    base = cyc;
    skip = 0;
    for (int k = 0; k < n_prog; k++) begin
      if (skip > 0) begin skip--; continue; end        // R7 squashed slots
      if (!p_v[k]) continue;                           // R9 bubbles
      e.pc  = p_pc[k];
      e.cyc = base + 32'(k) + 32'd3;                   // R2 resolve at n+3
      e.is_take = 1'b1;
      if (p_irq[k])     e.cause = 3'd0;
      else if (p_fi[k]) e.cause = 3'd1;
      else if (p_fd[k]) e.cause = 3'd2;
      else if (p_fe[k]) e.cause = 3'd3;
      else if (p_fm[k]) e.cause = 3'd4;
      else begin e.is_take = 1'b0; e.cause = 3'd0; end
      if (e.is_take) skip = 3;
      exp_q.push_back(e);
    end
    for (int j = 0; j < n_prog + 4; j++) begin
      if (j > 0) begin @(posedge clk); #1; end
      if_valid_i       = (j < n_prog) ? p_v[j] : 1'b0;
      if_pc_i          = (j < n_prog) ? p_pc[j] : '0;
      if_pc_fault_i    = (j < n_prog) ? p_fi[j] : 1'b0;
      id_illegal_i     = (j >= 1 && j - 1 < n_prog) ? p_fd[j-1] : 1'b0;
      ex_overflow_i    = (j >= 2 && j - 2 < n_prog) ? p_fe[j-2] : 1'b0;
      mem_addr_fault_i = (j >= 3 && j - 3 < n_prog) ? p_fm[j-3] : 1'b0;
      ext_irq_i        = (j >= 3 && j - 3 < n_prog) ? p_irq[j-3] : 1'b0;
    end
    n_prog = 0;
    repeat (3) @(posedge clk);
    chk(exp_q.size() == 0, req, "events still expected after drain", 32'(exp_q.size()), 32'd0);
  endtask

  // Monitor: pops expected events and compares at the negative edge.
  logic        pend = 0;
  logic [2:0]  pend_cause, last_cause = 3'd0;
  logic [31:0] pend_epc, last_epc = '0;
  always @(negedge clk) begin
    if (rst_n && started) begin
      if (pend) begin
        chk(cause_o == pend_cause, "R6", "cause after take", 32'(cause_o), 32'(pend_cause));
        chk(epc_o == pend_epc, "R6", "epc after take", epc_o, pend_epc);
        last_cause = pend_cause; last_epc = pend_epc; pend = 0;
      end
      if (take_o || retire_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7", "unexpected event pc", commit_pc_o, 32'hFFFF_FFFF);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          chk(cyc == e.cyc, "R2", "event cycle", cyc, e.cyc);
          chk(take_o == e.is_take, "R8", "take vs retire", 32'(take_o), 32'(e.is_take));
          chk(commit_pc_o == e.pc, "R8", "commit pc", commit_pc_o, e.pc);
          if (e.is_take) begin
            chk(kill_if_o && kill_id_o && kill_ex_o && kill_wb_o && pc_sel_handler_o && !retire_o,
                "R5", "kill/select lines", {27'd0, kill_if_o, kill_id_o, kill_ex_o, kill_wb_o, pc_sel_handler_o},
                32'h1F);
            chk(handler_pc_o == HANDLER, "R5", "handler pc", handler_pc_o, HANDLER);
            pend = 1; pend_cause = e.cause; pend_epc = e.pc;
          end else begin
            chk(cause_o == last_cause && epc_o == last_epc, "R6", "cause/epc held", epc_o, last_epc);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!take_o && !retire_o && !pc_sel_handler_o, "R1", "events in reset", 32'(take_o), 32'd0);
    chk(cause_o == 3'd0 && epc_o == '0, "R1", "regs in reset", epc_o, 32'd0);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!take_o && !retire_o && !kill_if_o && !kill_wb_o, "R1", "idle after reset", 32'(take_o), 32'd0);
    started = 1;

    // R8: clean stream
    for (int i = 0; i < 4; i++) add(1, 32'h100 + 32'(i*4), 0, 0, 0, 0, 0);
    run_prog("R8");

    // R2/R5/R7: illegal at decode; younger slots carry faults and are squashed
    add(1, 32'h200, 0, 0, 0, 0, 0);
    add(1, 32'h204, 0, 1, 0, 0, 0);
    add(1, 32'h208, 0, 0, 1, 0, 0);
    add(1, 32'h20C, 0, 0, 0, 1, 0);
    add(1, 32'h210, 1, 0, 0, 0, 1);
    add(1, 32'h214, 0, 0, 0, 0, 0);
    run_prog("R7");

    // R3: earliest stage wins
    add(1, 32'h300, 1, 0, 1, 0, 0);
    for (int i = 0; i < 3; i++) add(1, 32'h304 + 32'(i*4), 0, 0, 0, 0, 0);
    add(1, 32'h310, 0, 1, 0, 1, 0);
    for (int i = 0; i < 3; i++) add(1, 32'h314 + 32'(i*4), 0, 0, 0, 0, 0);
    add(1, 32'h320, 0, 0, 1, 1, 0);
    for (int i = 0; i < 3; i++) add(1, 32'h324 + 32'(i*4), 0, 0, 0, 0, 0);
    add(1, 32'h330, 0, 0, 0, 1, 0);
    add(1, 32'h334, 0, 0, 0, 0, 0);
    run_prog("R3");

    // R4: interrupt overrides
    add(1, 32'h400, 0, 0, 0, 1, 1);
    for (int i = 0; i < 3; i++) add(1, 32'h404 + 32'(i*4), 0, 0, 0, 0, 0);
    add(1, 32'h410, 0, 0, 0, 0, 1);
    for (int i = 0; i < 3; i++) add(1, 32'h414 + 32'(i*4), 0, 0, 0, 0, 0);
    add(1, 32'h420, 1, 1, 0, 0, 1);
    add(1, 32'h424, 0, 0, 0, 0, 0);
    run_prog("R4");

    // R9: bubbles with every fault and an interrupt are ignored
    add(0, 32'h500, 1, 1, 1, 1, 1);
    add(1, 32'h504, 0, 0, 0, 0, 0);
    add(0, 32'h508, 0, 0, 0, 1, 0);
    add(1, 32'h50C, 0, 0, 0, 0, 0);
    add(0, 32'h510, 0, 0, 0, 0, 1);
    add(1, 32'h514, 0, 0, 0, 0, 0);
    run_prog("R9");

    repeat (2) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule